// File: doc/BRIEF.md
# Peripheral IO Pin Multiplexer

This block sits between a small set of serial peripherals (two UARTs, one SPI master and two two-wire serial controllers) and eight generic IO cells. Each cell needs an output value and an output enable, and it returns the level seen on the pad. Four of the cells are shared. Each shared cell carries one of two peripheral signals, and a small select register, written through a one-cycle write strobe, decides which one. The other four cells are wired to one signal each and have no select register.

Every peripheral signal has a fixed direction: output, input or bidirectional. The direction decides what the cell drives:

- An output signal drives the cell with its enable held high.
- An input signal leaves the cell undriven.
- A bidirectional signal supplies its own value and enable pair.

In the other direction, the pad level reaches an input or bidirectional signal only while that signal owns its cell. In every other case the peripheral sees a steady logic 1, which reads as an idle line.

Top module: `pinmux_fabric`

## Requirements
- R1: After reset every select register holds 0. Cells 0 to 3 then carry UART0 transmit, UART0 receive, two-wire-0 data and two-wire-0 clock respectively.
- R2: Cell 0 drives UART0 transmit with select 0 and the SPI clock with select 1. In both cases the cell output enable is 1.
- R3: The cell output and the enable are both 0 whenever a cell carries an input-only signal. This covers UART0 receive on cell 1 with select 0, SPI MISO on cell 3 with select 1, and UART1 receive on cell 5. With select 1, cell 1 carries SPI MOSI with enable 1.
- R4: With select 0, cells 2 and 3 pass the two-wire-0 data and clock value/enable pairs unchanged. With select 1, cell 2 drives SPI slave select with enable 1.
- R5: The pad level reaches an input-side peripheral signal only while its option is selected on the cell. Otherwise that signal reads 1. This applies to UART0 receive (cell 1, select 0), SPI MISO (cell 3, select 1), two-wire-0 data in (cell 2, select 0) and two-wire-0 clock in (cell 3, select 0).
- R6: Cells 4 to 7 always carry UART1 transmit (enable 1), UART1 receive (undriven), two-wire-1 data and two-wire-1 clock. The pad levels of cells 5, 6 and 7 always reach UART1 receive and the two two-wire-1 inputs.
- R7: A write is a cycle with `sel_we` high. The 3-bit `sel_idx` holds the cell number, and `sel_val` takes effect at that clock edge. A write to cell number 4 to 7 changes nothing, and the registers hold their values in any cycle with `sel_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Select register write strobe |
| sel_idx | input | 3 | Cell number addressed by a write |
| sel_val | input | 1 | Select value written |
| u0_txd | input | 1 | UART0 transmit from peripheral |
| u0_rxd | output | 1 | UART0 receive to peripheral |
| u1_txd | input | 1 | UART1 transmit from peripheral |
| u1_rxd | output | 1 | UART1 receive to peripheral |
| sp_clk | input | 1 | SPI clock from master |
| sp_mosi | input | 1 | SPI data out from master |
| sp_cs | input | 1 | SPI slave select from master |
| sp_miso | output | 1 | SPI data in to master |
| tw0_dat_o | input | 1 | Two-wire-0 data value |
| tw0_dat_oe | input | 1 | Two-wire-0 data enable |
| tw0_dat_i | output | 1 | Two-wire-0 data level returned |
| tw0_clk_o | input | 1 | Two-wire-0 clock value |
| tw0_clk_oe | input | 1 | Two-wire-0 clock enable |
| tw0_clk_i | output | 1 | Two-wire-0 clock level returned |
| tw1_dat_o | input | 1 | Two-wire-1 data value |
| tw1_dat_oe | input | 1 | Two-wire-1 data enable |
| tw1_dat_i | output | 1 | Two-wire-1 data level returned |
| tw1_clk_o | input | 1 | Two-wire-1 clock value |
| tw1_clk_oe | input | 1 | Two-wire-1 clock enable |
| tw1_clk_i | output | 1 | Two-wire-1 clock level returned |
| cell_out | output | 8 | Output value per IO cell |
| cell_oe | output | 8 | Output enable per IO cell |
| cell_in | input | 8 | Pad level per IO cell |

## Verification
A corrupted select register shows up at the ports immediately after the clock edge that corrupted it. The cell then drives the wrong peripheral's value or enable, and the receive path hands a pad level to the wrong peripheral while the owning one reads a constant 1. A write that lands on the wrong cell, or a write to a fixed cell that leaks into a shared one, likewise changes a cell's output bundle within that same cycle. Because every output is combinational from the registers, the next sample taken after each edge exposes such a fault without any wait.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  localparam int N_CELLS  = 8;
  localparam int N_MUXED  = 4;
  localparam int N_FIXED  = N_CELLS - N_MUXED;
  localparam int MUX_OPTS = 2;
  localparam int SEL_W    = (MUX_OPTS > 1) ? $clog2(MUX_OPTS) : 1;
  localparam int CIDX_W   = $clog2(N_CELLS);

  // Level a receive path shows when its signal does not own the cell.
  localparam logic IDLE_LVL = 1'b1;

  typedef enum logic [1:0] {
    SD_OUT   = 2'd0,
    SD_IN    = 2'd1,
    SD_BIDIR = 2'd2
  } sig_dir_e;

  typedef struct packed {
    logic val;
    logic en;
  } pad_drv_t;

  // Turns a peripheral signal into the value/enable pair a cell drives.
  function automatic pad_drv_t pad_from(sig_dir_e d, logic v, logic e);
    pad_drv_t r;
    case (d)
      SD_OUT:   begin r.val = v;    r.en = 1'b1; end
      SD_BIDIR: begin r.val = v;    r.en = e;    end
      default:  begin r.val = 1'b0; r.en = 1'b0; end
    endcase
    return r;
  endfunction

  // Passes the pad level only when the signal owns the cell.
  function automatic logic rx_gate(logic owns, logic pad);
    return owns ? pad : IDLE_LVL;
  endfunction

  // Direction of each dedicated cell, counted from the first fixed cell.
  function automatic sig_dir_e fixed_dir(int k);
    case (k)
      0:       return SD_OUT;
      1:       return SD_IN;
      default: return SD_BIDIR;
    endcase
  endfunction

endpackage

// File: rtl/pmx_sel_bank.sv
module pmx_sel_bank #(
  parameter int NUM = 4,
  parameter int SW  = 1,
  parameter int IW  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [SW-1:0]          wr_val,
  output logic [NUM-1:0][SW-1:0] sel_q,
  output logic [NUM-1:0]         wr_hit
);

  for (genvar k = 0; k < NUM; k++) begin : g_reg
    assign wr_hit[k] = wr_en && (wr_idx == IW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel_q[k] <= '0;
      else if (wr_hit[k]) sel_q[k] <= wr_val;
    end

    // R7
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[k] |=> sel_q[k] == $past(wr_val));
  end

  // R7
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel_q));

  // R7
  fixed_idx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= IW'(NUM))) |=> $stable(sel_q));

endmodule

// File: rtl/pmx_mux_cell.sv
module pmx_mux_cell
  import pmx_pkg::*;
#(
  parameter int OPTS = 2,
  parameter int SW   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pad_drv_t [OPTS-1:0]  src,
  input  logic [SW-1:0]        sel,
  input  logic                 pad_in,
  output pad_drv_t             drv,
  output logic [OPTS-1:0]      hit,
  output logic [OPTS-1:0]      rx
);

  // A select value past the last option falls back to option 0.
  always_comb begin
    hit = '0;
    drv = src[0];
    for (int i = 0; i < OPTS; i++) begin
      if (sel == SW'(i)) begin
        hit[i] = 1'b1;
        drv    = src[i];
      end
    end
    if (hit == '0) hit[0] = 1'b1;
  end

  for (genvar i = 0; i < OPTS; i++) begin : g_rx
    assign rx[i] = rx_gate(hit[i], pad_in);
  end

  // R5
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) == 1);

endmodule

// File: rtl/pmx_fixed_cell.sv
module pmx_fixed_cell
  import pmx_pkg::*;
#(
  parameter sig_dir_e DIR = SD_OUT
) (
  input  logic     sig_v,
  input  logic     sig_e,
  input  logic     pad_in,
  output pad_drv_t drv,
  output logic     rx
);

  assign drv = pad_from(DIR, sig_v, sig_e);
  assign rx  = rx_gate(DIR != SD_OUT, pad_in);

endmodule

// File: rtl/pinmux_fabric.sv
module pinmux_fabric
  import pmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [CIDX_W-1:0] sel_idx,
  input  logic [SEL_W-1:0]  sel_val,
  input  logic              u0_txd,
  output logic              u0_rxd,
  input  logic              u1_txd,
  output logic              u1_rxd,
  input  logic              sp_clk,
  input  logic              sp_mosi,
  input  logic              sp_cs,
  output logic              sp_miso,
  input  logic              tw0_dat_o,
  input  logic              tw0_dat_oe,
  output logic              tw0_dat_i,
  input  logic              tw0_clk_o,
  input  logic              tw0_clk_oe,
  output logic              tw0_clk_i,
  input  logic              tw1_dat_o,
  input  logic              tw1_dat_oe,
  output logic              tw1_dat_i,
  input  logic              tw1_clk_o,
  input  logic              tw1_clk_oe,
  output logic              tw1_clk_i,
  output logic [N_CELLS-1:0] cell_out,
  output logic [N_CELLS-1:0] cell_oe,
  input  logic [N_CELLS-1:0] cell_in
);

  logic [N_MUXED-1:0][SEL_W-1:0]   sel_q;
  logic [N_MUXED-1:0]              wr_hit;
  pad_drv_t [N_MUXED-1:0][MUX_OPTS-1:0] mux_src;
  logic [N_MUXED-1:0][MUX_OPTS-1:0]     mux_hit;
  logic [N_MUXED-1:0][MUX_OPTS-1:0]     mux_rx;
  pad_drv_t [N_CELLS-1:0]          cell_drv;
  logic [N_FIXED-1:0]              fix_v;
  logic [N_FIXED-1:0]              fix_e;
  logic [N_FIXED-1:0]              fix_rx;

  pmx_sel_bank #(
    .NUM (N_MUXED),
    .SW  (SEL_W),
    .IW  (CIDX_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (sel_we),
    .wr_idx (sel_idx),
    .wr_val (sel_val),
    .sel_q  (sel_q),
    .wr_hit (wr_hit)
  );

  // Option lists of the shared cells: index 0 is select 0.
  always_comb begin
    mux_src[0][0] = pad_from(SD_OUT,   u0_txd,    1'b1);
    mux_src[0][1] = pad_from(SD_OUT,   sp_clk,    1'b1);
    mux_src[1][0] = pad_from(SD_IN,    1'b0,      1'b0);
    mux_src[1][1] = pad_from(SD_OUT,   sp_mosi,   1'b1);
    mux_src[2][0] = pad_from(SD_BIDIR, tw0_dat_o, tw0_dat_oe);
    mux_src[2][1] = pad_from(SD_OUT,   sp_cs,     1'b1);
    mux_src[3][0] = pad_from(SD_BIDIR, tw0_clk_o, tw0_clk_oe);
    mux_src[3][1] = pad_from(SD_IN,    1'b0,      1'b0);
  end

  for (genvar c = 0; c < N_MUXED; c++) begin : g_mux
    pmx_mux_cell #(
      .OPTS (MUX_OPTS),
      .SW   (SEL_W)
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (mux_src[c]),
      .sel    (sel_q[c]),
      .pad_in (cell_in[c]),
      .drv    (cell_drv[c]),
      .hit    (mux_hit[c]),
      .rx     (mux_rx[c])
    );
  end

  // Dedicated cells: UART1 transmit, UART1 receive, two-wire-1 data, clock.
  always_comb begin
    fix_v[0] = u1_txd;    fix_e[0] = 1'b1;
    fix_v[1] = 1'b0;      fix_e[1] = 1'b0;
    fix_v[2] = tw1_dat_o; fix_e[2] = tw1_dat_oe;
    fix_v[3] = tw1_clk_o; fix_e[3] = tw1_clk_oe;
  end

  for (genvar f = 0; f < N_FIXED; f++) begin : g_fix
    pmx_fixed_cell #(
      .DIR (fixed_dir(f))
    ) u_cell (
      .sig_v  (fix_v[f]),
      .sig_e  (fix_e[f]),
      .pad_in (cell_in[N_MUXED+f]),
      .drv    (cell_drv[N_MUXED+f]),
      .rx     (fix_rx[f])
    );
  end

  for (genvar c = 0; c < N_CELLS; c++) begin : g_pad
    assign cell_out[c] = cell_drv[c].val;
    assign cell_oe[c]  = cell_drv[c].en;
  end

  // Receive paths back to the peripherals.
  assign u0_rxd    = mux_rx[1][0];
  assign tw0_dat_i = mux_rx[2][0];
  assign tw0_clk_i = mux_rx[3][0];
  assign sp_miso   = mux_rx[3][1];
  assign u1_rxd    = fix_rx[1];
  assign tw1_dat_i = fix_rx[2];
  assign tw1_clk_i = fix_rx[3];

  logic unused_rx;
  assign unused_rx = &{mux_rx[0], mux_rx[1][1], mux_rx[2][1], fix_rx[0],
                       mux_hit, wr_hit};

  // R5
  u0_rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[1] != '0) |-> u0_rxd);

  // R3
  miso_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[3] != '0) |-> (!cell_oe[3] && !cell_out[3]));

endmodule

// File: tb/sim_pinmux_fabric.sv
module sim_pinmux_fabric;

  localparam int CLK_P = 10;

  typedef struct {
    logic [7:0] out;
    logic [7:0] oe;
    logic [6:0] rx;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_we = 1'b0;
  logic [2:0] sel_idx = '0;
  logic sel_val = 1'b0;
  logic [12:0] po = '0;
  logic [7:0] ci = '0;
  logic u0_rxd, u1_rxd, sp_miso, tw0_dat_i, tw0_clk_i, tw1_dat_i, tw1_clk_i;
  logic [7:0] cell_out, cell_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic shadow [4];
  exp_t q[$];
  event got;

  always #(CLK_P/2) clk = ~clk;

  pinmux_fabric u0 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_idx(sel_idx), .sel_val(sel_val),
    .u0_txd(po[0]), .u0_rxd(u0_rxd), .u1_txd(po[8]), .u1_rxd(u1_rxd),
    .sp_clk(po[1]), .sp_mosi(po[2]), .sp_cs(po[3]), .sp_miso(sp_miso),
    .tw0_dat_o(po[4]), .tw0_dat_oe(po[5]), .tw0_dat_i(tw0_dat_i),
    .tw0_clk_o(po[6]), .tw0_clk_oe(po[7]), .tw0_clk_i(tw0_clk_i),
    .tw1_dat_o(po[9]), .tw1_dat_oe(po[10]), .tw1_dat_i(tw1_dat_i),
    .tw1_clk_o(po[11]), .tw1_clk_oe(po[12]), .tw1_clk_i(tw1_clk_i),
    .cell_out(cell_out), .cell_oe(cell_oe), .cell_in(ci)
  );

  // Expected ports from the requirement table and the shadow selects.
  function automatic exp_t model(logic [12:0] p, logic [7:0] c, string tag);
    exp_t e;
    e.tag = tag;
    {e.out[0], e.oe[0]} = shadow[0] ? {p[1], 1'b1} : {p[0], 1'b1};
    {e.out[1], e.oe[1]} = shadow[1] ? {p[2], 1'b1} : 2'b00;
    {e.out[2], e.oe[2]} = shadow[2] ? {p[3], 1'b1} : {p[4], p[5]};
    {e.out[3], e.oe[3]} = shadow[3] ? 2'b00        : {p[6], p[7]};
    {e.out[4], e.oe[4]} = {p[8], 1'b1};
    {e.out[5], e.oe[5]} = 2'b00;
    {e.out[6], e.oe[6]} = {p[9], p[10]};
    {e.out[7], e.oe[7]} = {p[11], p[12]};
    e.rx[0] = shadow[1] ? 1'b1 : c[1];
    e.rx[1] = shadow[3] ? c[3] : 1'b1;
    e.rx[2] = shadow[2] ? 1'b1 : c[2];
    e.rx[3] = shadow[3] ? 1'b1 : c[3];
    e.rx[4] = c[5];
    e.rx[5] = c[6];
    e.rx[6] = c[7];
    return e;
  endfunction

  task automatic step(input logic [12:0] p, input logic [7:0] c, input logic we,
                      input logic [2:0] idx, input logic v, input string tag);
    @(negedge clk);
    po = p; ci = c; sel_we = we; sel_idx = idx; sel_val = v;
    @(posedge clk);
    if (we && idx < 3'd4) shadow[idx] = v;
    #(CLK_P/4);
    q.push_back(model(p, c, tag));
    ->got;
  endtask

  // Monitor: pops each expected item and compares it with the ports.
  initial begin
    forever begin
      @(got);
      while (q.size() > 0) begin
        exp_t e;
        logic [6:0] act_rx;
        e = q.pop_front();
        act_rx = {tw1_clk_i, tw1_dat_i, u1_rxd, tw0_clk_i, tw0_dat_i, sp_miso, u0_rxd};
        checks++;
        if (cell_out !== e.out || cell_oe !== e.oe || act_rx !== e.rx) begin
          fails++;
          $display("FAIL %s: out=%h oe=%h rx=%b expected out=%h oe=%h rx=%b",
                   e.tag, cell_out, cell_oe, act_rx, e.out, e.oe, e.rx);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset selects
    step(13'h1555, 8'hA5, 1'b0, 3'd0, 1'b0, "R1");
    step(13'h0AAA, 8'h5A, 1'b0, 3'd0, 1'b0, "R1");
    // R2 cell 0 to SPI clock
    step(13'h0001, 8'h00, 1'b1, 3'd0, 1'b1, "R2");
    step(13'h0002, 8'h00, 1'b0, 3'd0, 1'b0, "R2");
    step(13'h0001, 8'hFF, 1'b0, 3'd0, 1'b0, "R2");
    // R3 cell 1 to MOSI; receive goes idle
    step(13'h0004, 8'h00, 1'b1, 3'd1, 1'b1, "R3");
    step(13'h0000, 8'h00, 1'b0, 3'd0, 1'b0, "R3");
    // R4 cell 2 to slave select, cell 3 to MISO
    step(13'h0008, 8'h00, 1'b1, 3'd2, 1'b1, "R4");
    step(13'h00F0, 8'h00, 1'b1, 3'd3, 1'b1, "R4");
    // R5 MISO follows pad 3, two-wire-0 inputs idle
    step(13'h1FFF, 8'h08, 1'b0, 3'd0, 1'b0, "R5");
    step(13'h1FFF, 8'h00, 1'b0, 3'd0, 1'b0, "R5");
    // R7 writes to fixed cell numbers and strobe-less cycles change nothing
    step(13'h0000, 8'h00, 1'b1, 3'd5, 1'b0, "R7");
    step(13'h0000, 8'h00, 1'b1, 3'd7, 1'b0, "R7");
    step(13'h0000, 8'h00, 1'b1, 3'd4, 1'b0, "R7");
    step(13'h0000, 8'h00, 1'b0, 3'd0, 1'b0, "R7");
    step(13'h0000, 8'h00, 1'b0, 3'd3, 1'b0, "R7");
    // R5 restore owners of cells 1 and 3 and watch the pad return
    step(13'h0000, 8'h00, 1'b1, 3'd1, 1'b0, "R5");
    step(13'h0000, 8'h00, 1'b1, 3'd3, 1'b0, "R5");
    step(13'h0000, 8'h0A, 1'b0, 3'd0, 1'b0, "R5");
    step(13'h00F0, 8'h0C, 1'b1, 3'd2, 1'b0, "R4");
    // R6 dedicated cells under varied patterns
    for (int i = 0; i < 8; i++)
      step(13'((i + 1) * 1237), 8'((i + 3) * 53), 1'b0, 3'd0, 1'b0, "R6");
    // R2 back to UART0 transmit on cell 0
    step(13'h0001, 8'h00, 1'b1, 3'd0, 1'b0, "R2");
    step(13'h0000, 8'h00, 1'b0, 3'd0, 1'b0, "R2");
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule